// File: doc/BRIEF.md
# MDIO Management Command Engine

This block gives a host a compact way to reach the management registers of an attached Ethernet PHY. The host writes one 32-bit command word. That word carries the PHY address, the PHY register number, a read/write selector and, for writes, sixteen data bits. The block then serializes a complete management frame on MDIO, timed by an MDC clock that it divides down from the system clock. While the frame is in flight, a busy flag stays set. When a read completes, the captured data lands in the low half of the same word and a read-valid flag rises.

A second, independent register holds the 5-bit address of the attached PHY, so that software can keep it beside the command word. The expected use is simple: poll busy until it clears, write a command, then poll busy again. After a read, software takes the data and the valid flag from the command word. Every transaction finishes within a fixed, small number of system clocks, far below a 10 ms software timeout at any practical clock rate.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0, the PHY address word reads 0, MDC is low and `mdio_oe` is low.
- R2: A command-word write (`host_sel`=0) while not busy is accepted. From the next cycle the command word reads back write data in bits 15:0, PHY address in 20:16, register number in 25:21, operation in bit 26 (1 = read, 0 = write) and busy (bit 28) set. Host values written to bits 31:27 have no effect on the readback.
- R3: A command-word write while busy is ignored. The readback fields are unchanged and the frame on MDIO is that of the first command.
- R4: A write frame is, MSB first: 32 ones, 01, 01, five PHY address bits, five register bits, 10, sixteen data bits. Every bit is driven with `mdio_oe` high and changes only as MDC falls.
- R5: A read frame drives 32 ones, 01, 10, the PHY address and the register number (46 bits). It then holds `mdio_oe` low for the two turnaround bits and the sixteen data bits.
- R6: On a read, the block samples `mdio_i` on the rising MDC edge of each data bit, MSB first. When busy clears, bits 15:0 hold that data and bit 27 (read-valid) is 1.
- R7: Accepting a new command clears read-valid. Read-valid and busy are never 1 together.
- R8: MDC has a period of 2*HALF_DIV system clocks. Busy clears no later than 2*HALF_DIV*66 cycles after acceptance.
- R9: A write to the PHY address word (`host_sel`=1) stores only bits 4:0. Bits 31:5 always read 0.
- R10: Outside a frame `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Write target: 0 command word, 1 PHY address word |
| host_wdata | input | 32 | Host write data |
| cmd_word | output | 32 | Command word readback with busy and read-valid flags |
| phy_addr_word | output | 32 | PHY address word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data sampled in |

## Verification
The bench models a PHY that records every driven bit and its output enable on each MDC fall. During the data phase it returns a chosen half-word, so any swap in field order, wrong op or turnaround code, or off-by-one in the bit count shows up as a mismatched frame. A second command issued mid-frame targets the ignore-while-busy rule: a design that accepted it would corrupt the readback fields or restart the frame. The extremes of address and data (all zeros, all ones) probe field packing and sampling. The sampling edge is probed too, since a design that sampled on the wrong edge or dropped the last data bit would return shifted read data. Back-to-back read-then-write sequences catch a read-valid flag that survives a new command. The PHY address word is also written with all ones to catch upper bits that are not masked.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS = 32;

    // bit counter values inside a 64-bit frame
    localparam logic [6:0] FRAME_LEN = 7'd64;
    localparam logic [6:0] TA_FIRST  = 7'd46;
    localparam logic [6:0] DATA_FIRST = 7'd48;

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic        is_read;
        logic [15:0] data;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t unpack_cmd(input logic [31:0] w);
        mgmt_cmd_t c;
        c.data    = w[15:0];
        c.phy     = w[20:16];
        c.regn    = w[25:21];
        c.is_read = w[26];
        return c;
    endfunction

    function automatic logic [63:0] build_frame(input mgmt_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] payload;
        op      = c.is_read ? 2'b10 : 2'b01;
        ta      = c.is_read ? 2'b11 : 2'b10;
        payload = c.is_read ? 16'hFFFF : c.data;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, payload};
    endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF_DIV - 1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R8
    mdc_edge_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc != $past(mdc)) |-> $past(wrap));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mgmt_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        active,
    output logic [15:0] rd_data
);
    logic [63:0] shreg;
    logic [6:0]  bitcnt;
    logic        run;
    logic        rd_op;

    assign active = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bitcnt  <= '0;
            run     <= 1'b0;
            rd_op   <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (start) begin
                    shreg  <= build_frame(cmd);
                    bitcnt <= '0;
                    run    <= 1'b1;
                    rd_op  <= cmd.is_read;
                end
            end else if (fall_tick && bitcnt < FRAME_LEN) begin
                mdio_o  <= shreg[63];
                shreg   <= {shreg[62:0], 1'b1};
                mdio_oe <= !(rd_op && bitcnt >= TA_FIRST);
                bitcnt  <= bitcnt + 7'd1;
            end else if (rise_tick && bitcnt != 7'd0) begin
                if (rd_op && bitcnt > DATA_FIRST)
                    rd_data <= {rd_data[14:0], mdio_i};
                if (bitcnt == FRAME_LEN) begin
                    run     <= 1'b0;
                    done    <= 1'b1;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end
            end
        end
    end

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (run && rd_op && bitcnt > TA_FIRST) |-> !mdio_oe);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mdio_oe);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] cmd_word,
    output logic [31:0] phy_addr_word,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_cmd_t   cur;
    logic        busy;
    logic        rd_valid;
    logic [4:0]  phy_addr_q;
    logic        accept;
    logic        rise_tick;
    logic        fall_tick;
    logic        eng_done;
    logic        eng_active;
    logic [15:0] eng_rdata;
    logic        unused_hi;

    assign unused_hi = ^host_wdata[31:27];
    assign accept    = host_we && !host_sel && !busy;

    mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk(clk), .rst(rst), .mdc(mdc),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame u_frame (
        .clk(clk), .rst(rst), .start(accept), .cmd(unpack_cmd(host_wdata)),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done),
        .active(eng_active), .rd_data(eng_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            busy       <= 1'b0;
            rd_valid   <= 1'b0;
            phy_addr_q <= '0;
        end else begin
            if (host_we && host_sel)
                phy_addr_q <= host_wdata[4:0];
            if (accept) begin
                cur      <= unpack_cmd(host_wdata);
                busy     <= 1'b1;
                rd_valid <= 1'b0;
            end else if (eng_done) begin
                busy <= 1'b0;
                if (cur.is_read) begin
                    cur.data <= eng_rdata;
                    rd_valid <= 1'b1;
                end
            end
        end
    end

    assign cmd_word      = {3'b000, busy, rd_valid, cur.is_read, cur.regn, cur.phy, cur.data};
    assign phy_addr_word = {27'd0, phy_addr_q};

    // R2
    busy_covers_frame_chk: assert property (@(posedge clk) disable iff (rst)
        eng_active |-> busy);

    // R3
    ignore_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && !host_sel && busy) |=> $stable(cmd_word[26:16]));

    // R7
    valid_busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_word[28] && cmd_word[27]));

    // R9
    phy_addr_store_chk: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_sel) |=> phy_addr_word[4:0] == $past(host_wdata[4:0]));

endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int BOUND = 2 * HALF * 66;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cmd_word;
    logic [31:0] phy_addr_word;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap;
    logic [63:0] oecap;
    int          fidx = 0;
    bit          inframe = 1'b0;
    logic [15:0] phy_rd = 16'hFFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_cmd_engine #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .cmd_word(cmd_word), .phy_addr_word(phy_addr_word),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    initial mdio_i = 1'b1;

    // PHY model: records each bit presented on an MDC fall, answers reads
    always @(negedge mdc) begin
        #1;
        if (!inframe && fidx == 0 && mdio_oe) inframe = 1'b1;
        if (inframe) begin
            cap[63-fidx]   = mdio_o;
            oecap[63-fidx] = mdio_oe;
            if (fidx >= 48) mdio_i = phy_rd[63-fidx];
            fidx++;
            if (fidx == 64) inframe = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                              input logic rd, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [4:0] p, input logic [4:0] r, input logic rd,
                          input logic [15:0] d, input logic [15:0] rdval,
                          input logic [1:0] junk);
        logic [31:0] w;
        logic [63:0] ef;
        int cyc;
        w = {3'b000, junk, rd, r, p, d};
        phy_rd = rdval;
        fidx = 0;
        inframe = 1'b0;
        host_write(1'b0, w);
        cyc = 1;
        chk("R2 accepted fields", cmd_word, {3'b000, 1'b1, 1'b0, rd, r, p, d});
        chk("R7 valid cleared on new command", {31'd0, cmd_word[27]}, 32'd0);
        host_write(1'b0, {5'b00000, ~rd, ~r, ~p, ~d});
        cyc += 2;
        chk("R3 busy write ignored", cmd_word, {3'b000, 1'b1, 1'b0, rd, r, p, d});
        while (cmd_word[28] && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 completion bound", {31'd0, cyc <= BOUND}, 32'd1);
        ef = exp_frame(p, r, rd, d);
        if (rd) begin
            chk("R5 read frame head", cap[63:32], ef[63:32]);
            chk("R5 read frame addr", {cap[31:18], 18'd0}, {ef[31:18], 18'd0});
            chk("R5 read oe high", oecap[63:32], 32'hFFFF_FFFF);
            chk("R5 read oe release", oecap[31:0], 32'hFFFC_0000);
            chk("R6 read result", cmd_word, {3'b000, 1'b0, 1'b1, 1'b1, r, p, rdval});
        end else begin
            chk("R4 write frame head", cap[63:32], ef[63:32]);
            chk("R4 write frame tail", cap[31:0], ef[31:0]);
            chk("R4 write oe", oecap[31:0] & oecap[63:32], 32'hFFFF_FFFF);
            chk("R4 write result", cmd_word, {3'b000, 1'b0, 1'b0, 1'b0, r, p, d});
        end
        chk("R10 idle release", {31'd0, mdio_oe}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        time t0;
        time t1;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R1 reset cmd", cmd_word, 32'd0);
        chk("R1 reset phy", phy_addr_word, 32'd0);
        chk("R1 reset pins", {30'd0, mdc, mdio_oe}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", cmd_word, 32'd0);

        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk("R8 mdc period", 32'(t1 - t0), 32'(2 * HALF * CLK_PERIOD));

        host_write(1'b1, 32'hFFFF_FFFF);
        chk("R9 phy addr mask", phy_addr_word, 32'h0000_001F);
        host_write(1'b1, 32'h1234_56A5);
        chk("R9 phy addr low", phy_addr_word, 32'h0000_0005);

        do_cmd(5'd31, 5'd31, 1'b0, 16'hFFFF, 16'h0000, 2'b11);
        do_cmd(5'd0, 5'd0, 1'b0, 16'h0000, 16'h0000, 2'b00);
        do_cmd(5'd31, 5'd31, 1'b1, 16'h0000, 16'hFFFF, 2'b10);
        do_cmd(5'd0, 5'd0, 1'b1, 16'hFFFF, 16'h0000, 2'b01);
        do_cmd(5'd1, 5'd16, 1'b1, 16'h1111, 16'hA5C3, 2'b11);
        do_cmd(5'd9, 5'd2, 1'b0, 16'h8001, 16'h0000, 2'b00);

        for (int i = 0; i < 8; i++) begin
            logic [31:0] rv;
            logic [31:0] rv2;
            rv  = $urandom;
            rv2 = $urandom;
            do_cmd(rv[4:0], rv[9:5], rv[10], rv[31:16], rv2[15:0], rv2[17:16]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule